// File: doc/BRIEF.md
# Multi-channel peripheral stream DMA

This engine moves samples between the data registers of FIFO-based peripherals and valid/ready word streams. Channels numbered below `NS` are source channels. Each one reads its peripheral register and packs the samples, least significant byte first, into 32-bit stream words. The remaining `ND` channels are destination channels. Each one unpacks incoming stream words into register writes. Every channel is wired to one fixed register address, `BASE + index * STRIDE`. Transfer settings are loaded once when the channel starts and cannot be changed while it runs.

All channels share one register master port. A pulse on a channel's trigger input, typically a FIFO-threshold strobe, requests one burst. The length of that burst is the channel's per-trigger depth, or the remaining sample count if that is smaller. Bursts are granted one at a time in rotating order. When a channel's total sample count runs out, it pulses `done` and drops `active`.

Top module: `pstream_dma`

## Requirements
- R1: A `cfg_start` pulse on an inactive channel loads its size code, depth and total and raises `active`. The pulse is ignored if the channel is already active or if the supplied total or depth is zero. After reset no channel is active.
- R2: Each granted burst performs min(depth, remaining total) accesses, one per accepted bus cycle. Source channels read (`bus_we`=0) and destination channels write (`bus_we`=1).
- R3: The bus address of channel i is `BASE + i*STRIDE`. Grants search upward from a rotating pointer. The pointer moves to one past the served channel only when that channel's burst completes, and bursts never interleave.
- R4: A trigger on an inactive channel is ignored. A trigger arriving while that channel's burst is running queues exactly one further burst.
- R5: Size code 0 means a 1-byte sample, code 1 a 2-byte sample, and codes 2 and 3 a 4-byte sample. Source samples taken from the low bytes of `bus_rdata` fill a stream word from byte 0 upward.
- R6: A source word is presented when all 4 bytes are filled, with `os_tlast`=0. When the final sample of the total arrives, the word is presented at once, zero-padded, with `os_tlast`=1.
- R7: While a source word is presented and not accepted, its data and last flag stay stable and the channel issues no further reads.
- R8: `is_tready` is high only when the destination channel is active and holds no word. The write data is the next unconsumed sample, taken from byte 0 upward and zero-extended.
- R9: When a destination channel's total expires, any bytes left unconsumed in its held word are discarded. On a later restart the channel is ready for a fresh word immediately.
- R10: While `bus_rdy` is low, the pending access stays asserted with the same address and no channel state advances.
- R11: When a channel's last sample is transferred, `done` pulses for one cycle and `active` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | NS+ND | Per-channel start pulse |
| cfg_size | input | 2*(NS+ND) | Per-channel sample size code |
| cfg_depth | input | (NS+ND)*DEPW | Per-channel samples per trigger |
| cfg_total | input | (NS+ND)*CNTW | Per-channel total samples |
| trig | input | NS+ND | Per-channel burst request pulse |
| active | output | NS+ND | Channel running |
| done | output | NS+ND | One-cycle completion pulse |
| bus_en | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the accepted cycle |
| bus_rdy | input | 1 | Access accepted this cycle |
| os_tvalid | output | NS | Outgoing stream valid, one per source channel |
| os_tdata | output | 32*NS | Outgoing stream words |
| os_tlast | output | NS | Final word of a transfer |
| os_tready | input | NS | Outgoing stream ready |
| is_tvalid | input | ND | Incoming stream valid, one per destination channel |
| is_tdata | input | 32*ND | Incoming stream words |
| is_tready | output | ND | Incoming stream ready |

## Verification
A source channel can complete a read access that flushes a word in the same cycle as a trigger lands on that channel. A destination channel can finish its final write in the same cycle as a new start or trigger arrives elsewhere. The bench provokes these overlaps by running every channel concurrently with random triggers, restarts, stream stalls and bus stalls. A behavioural model built from queues and integers predicts every port on every clock, and any difference in bus address, direction, data, stream word or done timing is reported.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // bytes in one sample for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/psd_rr_pick.sv
module psd_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  // scan from the highest offset down so the nearest request wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(ptr) + k) % N);
      end
    end
  end
endmodule

// File: rtl/psd_src_lane.sv
module psd_src_lane
  import psd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic        last,
  input  logic [1:0]  size,
  input  logic [31:0] rdata,
  output logic        can,
  output logic        ovalid,
  output logic [31:0] odata,
  output logic        olast,
  input  logic        oready
);
  logic [31:0] pack_q, merged;
  logic [2:0]  fill_q, fill_n;

  always_comb begin
    merged = pack_q | ((rdata & size_mask(size)) << {fill_q, 3'b000});
    fill_n = fill_q + size_bytes(size);
  end

  assign can = !ovalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pack_q <= '0;
      fill_q <= '0;
      ovalid <= 1'b0;
      odata  <= '0;
      olast  <= 1'b0;
    end else begin
      if (ovalid && oready) ovalid <= 1'b0;
      if (acc) begin
        if (fill_n == 3'd4 || last) begin
          odata  <= merged;
          olast  <= last;
          ovalid <= 1'b1;
          pack_q <= '0;
          fill_q <= '0;
        end else begin
          pack_q <= merged;
          fill_q <= fill_n;
        end
      end
    end
  end

  // R7: a presented word holds until taken
  a_r7_word_hold: assert property (@(posedge clk) disable iff (rst)
    ovalid && !oready |=> ovalid && $stable(odata) && $stable(olast));
  // R7: no read lands while a word is waiting
  a_r7_no_read_when_full: assert property (@(posedge clk) disable iff (rst)
    acc |-> !ovalid);
endmodule

// File: rtl/psd_dst_lane.sv
module psd_dst_lane
  import psd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        act,
  input  logic        acc,
  input  logic        last,
  input  logic [1:0]  size,
  input  logic        itvalid,
  input  logic [31:0] itdata,
  output logic        itready,
  output logic        can,
  output logic [31:0] wdata
);
  logic [31:0] word_q;
  logic        held_q;
  logic [2:0]  off_q, off_n;

  assign off_n   = off_q + size_bytes(size);
  assign itready = act && !held_q;
  assign can     = held_q;
  assign wdata   = (word_q >> {off_q, 3'b000}) & size_mask(size);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      held_q <= 1'b0;
      off_q  <= '0;
    end else begin
      if (itvalid && itready) begin
        word_q <= itdata;
        held_q <= 1'b1;
        off_q  <= '0;
      end
      if (acc) begin
        if (off_n == 3'd4 || last) begin
          held_q <= 1'b0;
          off_q  <= '0;
        end else begin
          off_q <= off_n;
        end
      end
    end
  end

  // R8: an accepted word is held in the following cycle
  a_r8_word_taken: assert property (@(posedge clk) disable iff (rst)
    itvalid && itready |=> !itready);
  // R8: writes only drain a held word
  a_r8_write_needs_word: assert property (@(posedge clk) disable iff (rst)
    acc |-> !itready);
endmodule

// File: rtl/pstream_dma.sv
module pstream_dma #(
  parameter int              NS     = 2,
  parameter int              ND     = 2,
  parameter int              AW     = 16,
  parameter int              DEPW   = 4,
  parameter int              CNTW   = 12,
  parameter logic [AW-1:0]   BASE   = 16'h0400,
  parameter logic [AW-1:0]   STRIDE = 16'h0010
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NS+ND-1:0]       cfg_start,
  input  logic [2*(NS+ND)-1:0]   cfg_size,
  input  logic [(NS+ND)*DEPW-1:0] cfg_depth,
  input  logic [(NS+ND)*CNTW-1:0] cfg_total,
  input  logic [NS+ND-1:0]       trig,
  output logic [NS+ND-1:0]       active,
  output logic [NS+ND-1:0]       done,
  output logic                   bus_en,
  output logic                   bus_we,
  output logic [AW-1:0]          bus_addr,
  output logic [31:0]            bus_wdata,
  input  logic [31:0]            bus_rdata,
  input  logic                   bus_rdy,
  output logic [NS-1:0]          os_tvalid,
  output logic [32*NS-1:0]       os_tdata,
  output logic [NS-1:0]          os_tlast,
  input  logic [NS-1:0]          os_tready,
  input  logic [ND-1:0]          is_tvalid,
  input  logic [32*ND-1:0]       is_tdata,
  output logic [ND-1:0]          is_tready
);
  localparam int N  = NS + ND;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [CNTW-1:0] tot_q [N];
  logic [1:0]      sz_q  [N];
  logic [DEPW-1:0] dep_q [N];
  logic [N-1:0]    pend_q, can;
  logic            eng_busy;
  logic [IW-1:0]   eng_ch, rr_ptr, pick;
  logic [CNTW-1:0] eng_left, blen, dz;
  logic            pick_any, acc, last_s;
  logic [31:0]     dwd [ND];

  psd_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req(active & pend_q), .ptr(rr_ptr), .any(pick_any), .idx(pick));

  assign bus_en   = eng_busy && can[eng_ch];
  assign acc      = bus_en && bus_rdy;
  assign last_s   = (tot_q[eng_ch] == CNTW'(1));
  assign bus_we   = (int'(eng_ch) >= NS);
  assign bus_addr = BASE + AW'(eng_ch) * STRIDE;
  assign dz       = CNTW'(dep_q[pick]);
  assign blen     = (dz < tot_q[pick]) ? dz : tot_q[pick];

  always_comb begin
    bus_wdata = '0;
    for (int k = 0; k < ND; k++)
      if (int'(eng_ch) == NS + k) bus_wdata = dwd[k];
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    psd_src_lane u_lane (
      .clk(clk), .rst(rst),
      .acc(acc && eng_ch == IW'(s)), .last(last_s), .size(sz_q[s]),
      .rdata(bus_rdata), .can(can[s]),
      .ovalid(os_tvalid[s]), .odata(os_tdata[32*s +: 32]),
      .olast(os_tlast[s]), .oready(os_tready[s]));
  end

  for (genvar d = 0; d < ND; d++) begin : g_dst
    psd_dst_lane u_lane (
      .clk(clk), .rst(rst), .act(active[NS+d]),
      .acc(acc && eng_ch == IW'(NS + d)), .last(last_s), .size(sz_q[NS+d]),
      .itvalid(is_tvalid[d]), .itdata(is_tdata[32*d +: 32]),
      .itready(is_tready[d]), .can(can[NS+d]), .wdata(dwd[d]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= '0;
      done     <= '0;
      pend_q   <= '0;
      eng_busy <= 1'b0;
      eng_ch   <= '0;
      eng_left <= '0;
      rr_ptr   <= '0;
      for (int i = 0; i < N; i++) begin
        tot_q[i] <= '0;
        sz_q[i]  <= '0;
        dep_q[i] <= '0;
      end
    end else begin
      done <= '0;
      for (int i = 0; i < N; i++) begin
        if (cfg_start[i] && !active[i] && cfg_total[i*CNTW +: CNTW] != '0
            && cfg_depth[i*DEPW +: DEPW] != '0) begin
          active[i] <= 1'b1;
          tot_q[i]  <= cfg_total[i*CNTW +: CNTW];
          sz_q[i]   <= cfg_size[2*i +: 2];
          dep_q[i]  <= cfg_depth[i*DEPW +: DEPW];
          pend_q[i] <= 1'b0;
        end else if (trig[i] && active[i]) begin
          pend_q[i] <= 1'b1;
        end else if (!eng_busy && pick_any && pick == IW'(i)) begin
          pend_q[i] <= 1'b0;
        end
      end
      if (!eng_busy && pick_any) begin
        eng_busy <= 1'b1;
        eng_ch   <= pick;
        eng_left <= blen;
      end
      if (acc) begin
        tot_q[eng_ch] <= tot_q[eng_ch] - 1'b1;
        eng_left      <= eng_left - 1'b1;
        if (eng_left == CNTW'(1)) begin
          eng_busy <= 1'b0;
          rr_ptr   <= (eng_ch == IW'(N - 1)) ? '0 : eng_ch + 1'b1;
        end
        if (last_s) begin
          active[eng_ch] <= 1'b0;
          done[eng_ch]   <= 1'b1;
        end
      end
    end
  end

  // R2: only a running channel owns the bus
  a_r2_bus_owner: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> active[eng_ch]);
  // R3: rotation moves only when a burst closes
  a_r3_ptr_moves: assert property (@(posedge clk) disable iff (rst)
    !$stable(rr_ptr) |-> $fell(eng_busy));
  // R10: a refused access is held unchanged
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_rdy |=> bus_en && $stable(bus_addr) && $stable(bus_wdata));
  // R11: at most one completion per cycle, and it clears the channel
  a_r11_done_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
  a_r11_done_drops: assert property (@(posedge clk) disable iff (rst)
    (done & active) == '0);
endmodule

// File: tb/pstream_dma_tb_top.sv
module pstream_dma_tb_top;
  localparam int NS = 2, ND = 2, N = 4, AW = 16, DEPW = 4, CNTW = 12;
  localparam logic [15:0] BASE = 16'h0400, STRIDE = 16'h0010;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] cfg_start = '0, trig = '0;
  logic [2*N-1:0] cfg_size = '0;
  logic [N*DEPW-1:0] cfg_depth = '0;
  logic [N*CNTW-1:0] cfg_total = '0;
  logic [N-1:0] active, done;
  logic bus_en, bus_we, bus_rdy = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic [NS-1:0] os_tvalid, os_tlast, os_tready = '0;
  logic [32*NS-1:0] os_tdata;
  logic [ND-1:0] is_tvalid = '0, is_tready;
  logic [32*ND-1:0] is_tdata = '0;

  always #2 clk = ~clk;

  pstream_dma #(.NS(NS), .ND(ND), .AW(AW), .DEPW(DEPW), .CNTW(CNTW),
                .BASE(BASE), .STRIDE(STRIDE)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_act[N], m_tot[N], m_sz[N], m_dep[N], m_pend[N], m_done[N];
  int m_eb, m_ec, m_cnt, m_ptr;
  int m_ov[NS], m_ol[NS];
  logic [31:0] m_od[NS];
  logic [7:0] sq[NS][$];
  logic [7:0] dq[ND][$];

  function automatic int nbytes(int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  function automatic int can_m(int c);
    if (c < NS) return (m_ov[c] == 0) ? 1 : 0;
    return (dq[c-NS].size() != 0) ? 1 : 0;
  endfunction

  task automatic reset_model();
    for (int i = 0; i < N; i++) begin
      m_act[i] = 0; m_tot[i] = 0; m_sz[i] = 0; m_dep[i] = 0; m_pend[i] = 0; m_done[i] = 0;
    end
    for (int s = 0; s < NS; s++) begin m_ov[s] = 0; m_ol[s] = 0; m_od[s] = 0; sq[s].delete(); end
    for (int d = 0; d < ND; d++) dq[d].delete();
    m_eb = 0; m_ec = 0; m_cnt = 0; m_ptr = 0;
  endtask

  task automatic step_model();
    int a0[N];
    int rdy0[ND];
    int acc, g, c, nb, last;
    logic [31:0] w;
    for (int i = 0; i < N; i++) begin a0[i] = m_act[i]; m_done[i] = 0; end
    for (int d = 0; d < ND; d++) rdy0[d] = (m_act[NS+d] != 0 && dq[d].size() == 0) ? 1 : 0;
    acc = (m_eb != 0 && can_m(m_ec) != 0 && bus_rdy) ? 1 : 0;
    g = -1;
    if (m_eb == 0)
      for (int k = N - 1; k >= 0; k--)
        if (m_act[(m_ptr + k) % N] != 0 && m_pend[(m_ptr + k) % N] != 0) g = (m_ptr + k) % N;
    for (int s = 0; s < NS; s++) if (m_ov[s] != 0 && os_tready[s]) m_ov[s] = 0;
    for (int d = 0; d < ND; d++)
      if (rdy0[d] != 0 && is_tvalid[d]) begin
        w = is_tdata[32*d +: 32];
        for (int j = 0; j < 4; j++) dq[d].push_back(w[8*j +: 8]);
      end
    if (acc != 0) begin
      c = m_ec; nb = nbytes(m_sz[c]); last = (m_tot[c] == 1) ? 1 : 0;
      if (c < NS) begin
        for (int j = 0; j < nb; j++) sq[c].push_back(bus_rdata[8*j +: 8]);
        if (sq[c].size() == 4 || last != 0) begin
          w = '0;
          for (int j = 0; j < sq[c].size(); j++) w[8*j +: 8] = sq[c][j];
          m_od[c] = w; m_ol[c] = last; m_ov[c] = 1; sq[c].delete();
        end
      end else begin
        for (int j = 0; j < nb; j++) void'(dq[c-NS].pop_front());
        if (last != 0) dq[c-NS].delete();
      end
      m_tot[c]--; m_cnt--;
      if (m_cnt == 0) begin m_eb = 0; m_ptr = (c + 1) % N; end
      if (m_tot[c] == 0) begin m_act[c] = 0; m_done[c] = 1; end
    end
    if (g >= 0) begin
      m_eb = 1; m_ec = g; m_cnt = (m_dep[g] < m_tot[g]) ? m_dep[g] : m_tot[g];
    end
    for (int i = 0; i < N; i++) begin
      if (cfg_start[i] && a0[i] == 0 && cfg_total[i*CNTW +: CNTW] != 0 && cfg_depth[i*DEPW +: DEPW] != 0) begin
        m_act[i] = 1; m_tot[i] = int'(cfg_total[i*CNTW +: CNTW]);
        m_sz[i] = int'(cfg_size[2*i +: 2]); m_dep[i] = int'(cfg_depth[i*DEPW +: DEPW]); m_pend[i] = 0;
      end else if (trig[i] && a0[i] != 0) m_pend[i] = 1;
      else if (g == i) m_pend[i] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (rst) reset_model();
    else step_model();
  end

  // compare every port against the model, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      int e_en, nb;
      logic [31:0] ew;
      e_en = (m_eb != 0 && can_m(m_ec) != 0) ? 1 : 0;
      chk(bus_en == e_en[0], "R2", "bus_en", 32'(bus_en), 32'(e_en));
      if (e_en != 0) begin
        chk(bus_addr == BASE + 16'(m_ec) * STRIDE, "R3", "bus_addr", 32'(bus_addr), 32'(BASE + 16'(m_ec) * STRIDE));
        chk(bus_we == (m_ec >= NS), "R2", "bus_we", 32'(bus_we), 32'(m_ec >= NS));
        if (m_ec >= NS) begin
          nb = nbytes(m_sz[m_ec]); ew = '0;
          for (int j = 0; j < nb; j++) ew[8*j +: 8] = dq[m_ec-NS][j];
          chk(bus_wdata == ew, "R8", "bus_wdata", bus_wdata, ew);
        end
      end
      for (int i = 0; i < N; i++) begin
        chk(active[i] == (m_act[i] != 0), "R1", "active", 32'(active[i]), 32'(m_act[i]));
        chk(done[i] == (m_done[i] != 0), "R11", "done", 32'(done[i]), 32'(m_done[i]));
      end
      for (int s = 0; s < NS; s++) begin
        chk(os_tvalid[s] == (m_ov[s] != 0), "R7", "os_tvalid", 32'(os_tvalid[s]), 32'(m_ov[s]));
        if (m_ov[s] != 0) begin
          chk(os_tdata[32*s +: 32] == m_od[s], "R5", "os_tdata", os_tdata[32*s +: 32], m_od[s]);
          chk(os_tlast[s] == (m_ol[s] != 0), "R6", "os_tlast", 32'(os_tlast[s]), 32'(m_ol[s]));
        end
      end
      for (int d = 0; d < ND; d++)
        chk(is_tready[d] == (m_act[NS+d] != 0 && dq[d].size() == 0), "R8", "is_tready",
            32'(is_tready[d]), 32'(m_act[NS+d] != 0 && dq[d].size() == 0));
    end
  end

  task automatic setcfg(input int i, input int sz, input int dep, input int tot);
    cfg_size[2*i +: 2] = 2'(sz);
    cfg_depth[i*DEPW +: DEPW] = DEPW'(dep);
    cfg_total[i*CNTW +: CNTW] = CNTW'(tot);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int order[$];
    int cnt;
    logic [31:0] wq[$];
    repeat (4) @(negedge clk);
    chk(active == '0, "R1", "reset active", 32'(active), 0);
    chk(bus_en == 1'b0 && os_tvalid == '0 && done == '0, "R1", "reset bus/stream", 32'(bus_en), 0);
    rst = 1'b0; run = 1;

    // R3: all channels at once, rotation from channel 0
    os_tready = '1; is_tvalid = '1; is_tdata = {32'h55667788, 32'h11223344}; bus_rdy = 1'b1;
    setcfg(0, 1, 2, 2); setcfg(1, 0, 2, 2); setcfg(2, 2, 2, 2); setcfg(3, 1, 2, 2);
    @(negedge clk); cfg_start = '1;
    @(negedge clk); cfg_start = '0; trig = '1;
    @(negedge clk); trig = '0;
    for (int t = 0; t < 60; t++) begin
      if (bus_en && bus_rdy) order.push_back(int'((bus_addr - BASE) / STRIDE));
      @(negedge clk);
    end
    chk(order.size() == 8, "R3", "burst count", 32'(order.size()), 8);
    for (int j = 0; j < 8 && j < order.size(); j++)
      chk(order[j] == j / 2, "R3", "grant order", 32'(order[j]), 32'(j / 2));
    is_tvalid = '0;

    // R4: trigger on an idle channel is ignored
    trig[0] = 1'b1; @(negedge clk); trig[0] = 1'b0;
    setcfg(0, 0, 3, 7); cfg_start[0] = 1'b1; @(negedge clk); cfg_start[0] = 1'b0;
    cnt = 0;
    for (int t = 0; t < 10; t++) begin if (bus_en) cnt++; @(negedge clk); end
    chk(cnt == 0, "R4", "accesses after idle trigger", 32'(cnt), 0);
    trig[0] = 1'b1; @(negedge clk); trig[0] = 1'b0;
    cnt = 0;
    for (int t = 0; t < 20; t++) begin if (bus_en && bus_rdy) cnt++; @(negedge clk); end
    chk(cnt == 3, "R2", "burst length = depth", 32'(cnt), 3);
    trig[0] = 1'b1; @(negedge clk); trig[0] = 1'b1; @(negedge clk); trig[0] = 1'b0;
    cnt = 0;
    for (int t = 0; t < 30; t++) begin if (bus_en && bus_rdy) cnt++; @(negedge clk); end
    chk(cnt == 4, "R4", "queued second burst", 32'(cnt), 4);
    chk(active[0] == 1'b0, "R11", "channel finished", 32'(active[0]), 0);

    // R10 then R9: stalled bus, leftover bytes dropped
    is_tdata[31:0] = 32'hA1B2C3D4; is_tvalid[0] = 1'b1; bus_rdy = 1'b0;
    setcfg(2, 0, 2, 2); cfg_start[2] = 1'b1; @(negedge clk); cfg_start[2] = 1'b0;
    trig[2] = 1'b1; @(negedge clk); trig[2] = 1'b0;
    repeat (6) @(negedge clk);
    chk(bus_en && bus_addr == BASE + 16'h0020 && active[2], "R10", "held access", 32'(bus_addr), 32'(BASE + 16'h0020));
    bus_rdy = 1'b1;
    for (int t = 0; t < 8; t++) begin if (bus_en && bus_rdy) wq.push_back(bus_wdata); @(negedge clk); end
    chk(wq.size() == 2, "R8", "write count", 32'(wq.size()), 2);
    if (wq.size() == 2) begin
      chk(wq[0] == 32'hD4, "R8", "first sample", wq[0], 32'hD4);
      chk(wq[1] == 32'hC3, "R8", "second sample", wq[1], 32'hC3);
    end
    chk(is_tready[0] == 1'b0, "R8", "idle not ready", 32'(is_tready[0]), 0);
    is_tdata[31:0] = 32'h11223344;
    setcfg(2, 0, 1, 1); cfg_start[2] = 1'b1; @(negedge clk); cfg_start[2] = 1'b0;
    chk(is_tready[0] == 1'b1, "R9", "ready after restart", 32'(is_tready[0]), 1);
    trig[2] = 1'b1; @(negedge clk); trig[2] = 1'b0;
    wq.delete();
    for (int t = 0; t < 8; t++) begin if (bus_en && bus_rdy) wq.push_back(bus_wdata); @(negedge clk); end
    chk(wq.size() == 1 && wq[0] == 32'h44, "R9", "fresh word used", (wq.size() > 0) ? wq[0] : 32'hX, 32'h44);

    // random concurrent traffic, compared every cycle
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_start[i] = 1'b0;
        trig[i] = ($urandom % 5 == 0);
        if ($urandom % 40 == 0) begin
          setcfg(i, int'($urandom % 4), int'($urandom % 6), int'($urandom % 9));
          cfg_start[i] = 1'b1;
        end
      end
      os_tready = NS'($urandom);
      is_tvalid = ND'($urandom);
      is_tdata  = {$urandom, $urandom};
      bus_rdy   = ($urandom % 4 != 0);
      bus_rdata = $urandom;
      @(negedge clk);
    end
    cfg_start = '0; trig = '0; bus_rdy = 1'b1; os_tready = '1;
    repeat (4) @(negedge clk);
    run = 0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule